// File: doc/BRIEF.md
# Six-Channel Servo Pulse Generator

This block drives six single-edge pulse outputs for hobby servos and heater or fan switches from one shared timebase. A prescaler turns the system clock into a slow tick (1 MHz from 25 MHz by default). A period counter steps on every tick and wraps after a fixed count, which gives a 20 ms repetition period. At each wrap every enabled output goes high. Each output then drops when the counter reaches that channel's compare value.

Software reaches the block through a plain register-write port. Each write names a channel, a field and a value. A pulse width is clamped to the channel's lower and upper limits when it is written, and it lands in a shadow register. A per-channel latch request arms a commit, and the shadow value is copied into the live compare register only at the next period wrap. A pulse therefore never changes length in the middle of a period. The upper limit, and also the lower limit, is held at or below the period count minus a safety margin. A `frame_start` strobe marks each wrap.

Top module: `servo_pwm_core`

## Requirements
- R1: The period counter advances once every CLK_DIV clocks and wraps from PERIOD_TOP to 0, so a period lasts (PERIOD_TOP+1)*CLK_DIV clocks. `frame_start` is high for exactly one clock per period, at the wrap.
- R2: An enabled output goes high one clock after `frame_start` and stays high for CLK_DIV*C clocks, where C is its live compare value. It then drops when the counter reaches C. A compare value of 0 keeps the output low for the whole period.
- R3: A width write (field code 0) changes only the shadow register. The live compare value changes only at a period wrap, and only for a channel whose latch bit was set by its bit in `latch_set` before that wrap.
- R4: A channel's latch bit clears itself when its value is committed at the wrap. A later width write with no new latch request does not reach the output.
- R5: A width write stores max(min(v, upper), lower), using the limits in force at the time of the write. If lower > upper, lower wins. Lower is field code 1 and upper is field code 2. Changing a limit later does not re-clamp a shadow value that is already stored.
- R6: Both limit fields are stored capped at PERIOD_TOP - MAX_MARGIN, so no committed width can exceed that value.
- R7: The enable field (field code 3, data bit 0) acts at once. A disabled channel holds its output low and ignores the period-start set.
- R8: After reset, all compare and shadow registers are 0, all latch bits are clear, all channels are disabled, all outputs are low, the lower limits are 0 and the upper limits equal the cap.
- R9: A write whose channel index is NUM_CH or above changes no channel.
- R10: The channels are independent. A write, latch or enable change on one channel leaves every other channel's pulse width unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_ch | input | CH_W | Target channel index |
| cfg_field | input | 2 | Field code: 0 width, 1 lower limit, 2 upper limit, 3 enable |
| cfg_data | input | CNT_W | Write value (bit 0 for the enable field) |
| latch_set | input | NUM_CH | Per-channel request to commit the shadow width at the next wrap |
| pwm_out | output | NUM_CH | Pulse outputs |
| frame_start | output | 1 | One-clock strobe at each period wrap |

## Verification
The hardest case to reach from the ports is the gap between what is stored and what is shown. A shadow value can sit uncommitted while the old compare value keeps driving the pin, or a latch bit can have already cleared. The bench creates these states on purpose. It writes widths with no latch request and measures a whole period before and after a later latch. It raises a limit after a width is stored. It writes to channel indices that do not exist and then latches every channel, so that any stray shadow change would show up as a changed pulse length. All measurements use a small configuration (a 2-clock tick and a 20-tick period), so that a full sweep of widths across and past the limits fits in a short run.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

    typedef enum logic [1:0] {
        FLD_WIDTH  = 2'd0,
        FLD_LOWER  = 2'd1,
        FLD_UPPER  = 2'd2,
        FLD_ENABLE = 2'd3
    } cfg_field_e;

    // Saturate a value into [lo, hi]; lo takes precedence when lo > hi.
    function automatic logic [31:0] clamp_range(input logic [31:0] v,
                                                input logic [31:0] lo,
                                                input logic [31:0] hi);
        logic [31:0] t;
        t = (v > hi) ? hi : v;
        return (t < lo) ? lo : t;
    endfunction

    function automatic logic [31:0] cap_to(input logic [31:0] v,
                                           input logic [31:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/servo_pwm_timebase.sv
module servo_pwm_timebase #(
    parameter int CLK_DIV    = 25,
    parameter int PERIOD_TOP = 19999,
    parameter int CNT_W      = 15
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             frame_start
);
    localparam int PRE_W = $clog2(CLK_DIV + 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick = (pre_q == PRE_W'(CLK_DIV - 1));
    assign wrap = tick && (cnt == CNT_W'(PERIOD_TOP));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q       <= '0;
            cnt         <= '0;
            frame_start <= 1'b0;
        end else begin
            pre_q       <= tick ? '0 : pre_q + 1'b1;
            frame_start <= wrap;
            if (wrap)
                cnt <= '0;
            else if (tick)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/servo_pwm_chan.sv
module servo_pwm_chan
    import servo_pwm_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int CAP   = 19979
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  cfg_field_e       wr_field,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             latch_req,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    output logic             pwm,
    output logic             enabled,
    output logic             pending,
    output logic [CNT_W-1:0] active
);
    logic [CNT_W-1:0] lower_q, upper_q, shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lower_q  <= '0;
            upper_q  <= CNT_W'(CAP);
            shadow_q <= '0;
            active   <= '0;
            pending  <= 1'b0;
            enabled  <= 1'b0;
            pwm      <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (wr_field)
                    FLD_WIDTH:  shadow_q <= CNT_W'(clamp_range(32'(wr_data),
                                                   32'(lower_q), 32'(upper_q)));
                    FLD_LOWER:  lower_q  <= CNT_W'(cap_to(32'(wr_data), 32'(CAP)));
                    FLD_UPPER:  upper_q  <= CNT_W'(cap_to(32'(wr_data), 32'(CAP)));
                    FLD_ENABLE: enabled  <= wr_data[0];
                endcase
            end
            if (wrap && pending)
                active <= shadow_q;
            pending <= (pending && !wrap) || latch_req;
            pwm     <= enabled && (cnt < active);
        end
    end
endmodule

// File: rtl/servo_pwm_core.sv
module servo_pwm_core
    import servo_pwm_pkg::*;
#(
    parameter int NUM_CH     = 6,
    parameter int CLK_DIV    = 25,
    parameter int PERIOD_TOP = 19999,
    parameter int MAX_MARGIN = 20,
    parameter int CNT_W      = 15,
    parameter int CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_field,
    input  logic [CNT_W-1:0]  cfg_data,
    input  logic [NUM_CH-1:0] latch_set,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              frame_start
);
    localparam int CAP = PERIOD_TOP - MAX_MARGIN;

    logic [CNT_W-1:0]             cnt;
    logic                         wrap;
    logic [NUM_CH-1:0]            en_vec, pend_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] act_vec;
    cfg_field_e                   field_dec;

    assign field_dec = cfg_field_e'(cfg_field);

    servo_pwm_timebase #(
        .CLK_DIV(CLK_DIV), .PERIOD_TOP(PERIOD_TOP), .CNT_W(CNT_W)
    ) u_tb (
        .clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap), .frame_start(frame_start)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = cfg_we && (cfg_ch == CH_W'(i));
        servo_pwm_chan #(.CNT_W(CNT_W), .CAP(CAP)) u_ch (
            .clk(clk), .rst(rst), .wr_en(sel), .wr_field(field_dec),
            .wr_data(cfg_data), .latch_req(latch_set[i]), .wrap(wrap),
            .cnt(cnt), .pwm(pwm_out[i]), .enabled(en_vec[i]),
            .pending(pend_vec[i]), .active(act_vec[i])
        );
    end
endmodule

// File: rtl/servo_pwm_chk.sv
module servo_pwm_chk #(
    parameter int NUM_CH     = 6,
    parameter int PERIOD_TOP = 19999,
    parameter int MAX_MARGIN = 20,
    parameter int CNT_W      = 15
) (
    input logic                         clk,
    input logic                         rst,
    input logic [CNT_W-1:0]             cnt,
    input logic                         wrap,
    input logic                         frame_start,
    input logic [NUM_CH-1:0]            latch_set,
    input logic [NUM_CH-1:0]            en_vec,
    input logic [NUM_CH-1:0]            pend_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0] act_vec,
    input logic [NUM_CH-1:0]            pwm_out
);
    localparam int CAP = PERIOD_TOP - MAX_MARGIN;

    assert_wrap_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(PERIOD_TOP));

    assert_frame_single_R1: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_out[i]) |-> ($past(frame_start) ||
                                   ($past(en_vec[i]) && !$past(en_vec[i], 2))));

        assert_commit_at_wrap_R3: assert property (@(posedge clk) disable iff (rst)
            !wrap |=> $stable(act_vec[i]));

        assert_latch_clear_R4: assert property (@(posedge clk) disable iff (rst)
            (wrap && pend_vec[i] && !latch_set[i]) |=> !pend_vec[i]);

        assert_cap_R6: assert property (@(posedge clk) disable iff (rst)
            act_vec[i] <= CNT_W'(CAP));

        assert_disabled_low_R7: assert property (@(posedge clk) disable iff (rst)
            !en_vec[i] |=> !pwm_out[i]);
    end
endmodule

bind servo_pwm_core servo_pwm_chk #(
    .NUM_CH(NUM_CH), .PERIOD_TOP(PERIOD_TOP), .MAX_MARGIN(MAX_MARGIN), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap), .frame_start(frame_start),
    .latch_set(latch_set), .en_vec(en_vec), .pend_vec(pend_vec),
    .act_vec(act_vec), .pwm_out(pwm_out)
);

// File: tb/tb_servo_pwm_core.sv
module tb_servo_pwm_core;
    localparam int NCH  = 6;
    localparam int DIV  = 2;
    localparam int TOP  = 19;
    localparam int MARG = 2;
    localparam int W    = 5;
    localparam int CAPV = TOP - MARG;
    localparam int PCLK = (TOP + 1) * DIV;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [2:0]     cfg_ch = '0;
    logic [1:0]     cfg_field = '0;
    logic [W-1:0]   cfg_data = '0;
    logic [NCH-1:0] latch_set = '0;
    logic [NCH-1:0] pwm_out;
    logic           frame_start;

    servo_pwm_core #(
        .NUM_CH(NCH), .CLK_DIV(DIV), .PERIOD_TOP(TOP), .MAX_MARGIN(MARG), .CNT_W(W)
    ) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .latch_set(latch_set),
        .pwm_out(pwm_out), .frame_start(frame_start)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    int lo_m[NCH], hi_m[NCH], sh_m[NCH], act_m[NCH], meas[NCH];
    bit en_m[NCH], pend_m[NCH];
    int frame_gap;

    task automatic chk(input int actual, input int expected, input string tag);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic int clampm(int v, int lo, int hi);
        int t;
        t = (v > hi) ? hi : v;
        return (t < lo) ? lo : t;
    endfunction

    function automatic int capm(int v);
        return (v > CAPV) ? CAPV : v;
    endfunction

    task automatic wr(input int ch, input int fld, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_field = 2'(fld); cfg_data = W'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (ch < NCH) begin
            case (fld)
                0: sh_m[ch] = clampm(data, lo_m[ch], hi_m[ch]);
                1: lo_m[ch] = capm(data);
                2: hi_m[ch] = capm(data);
                default: en_m[ch] = data[0];
            endcase
        end
    endtask

    task automatic lat(input int mask);
        @(negedge clk);
        latch_set = NCH'(mask);
        @(negedge clk);
        latch_set = '0;
        for (int i = 0; i < NCH; i++) if (mask[i]) pend_m[i] = 1'b1;
    endtask

    // Wait for a wrap, then count high clocks on every channel for one period.
    task automatic measure();
        do @(negedge clk); while (!frame_start);
        for (int i = 0; i < NCH; i++) begin
            if (pend_m[i]) act_m[i] = sh_m[i];
            pend_m[i] = 1'b0;
            meas[i] = 0;
        end
        frame_gap = 0;
        for (int k = 1; k <= PCLK; k++) begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++) if (pwm_out[i]) meas[i]++;
            if (frame_start && frame_gap == 0) frame_gap = k;
        end
    endtask

    function automatic int exp_hi(int ch);
        return en_m[ch] ? DIV * act_m[ch] : 0;
    endfunction

    task automatic check_all(input string tag);
        for (int i = 0; i < NCH; i++) chk(meas[i], exp_hi(i), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            lo_m[i] = 0; hi_m[i] = CAPV; sh_m[i] = 0; act_m[i] = 0;
            en_m[i] = 1'b0; pend_m[i] = 1'b0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R8: reset state at the ports
        chk(int'(pwm_out), 0, "R8 outputs low after reset");
        chk(int'(frame_start), 0, "R8 frame strobe low after reset");
        measure();
        check_all("R8 idle period");
        // R8: enabling with zero compare still gives no pulse
        for (int i = 0; i < NCH; i++) wr(i, 3, 1);
        lat(63);
        measure();
        check_all("R8 zero compare after enable");

        // R10 / R1: distinct widths on every channel
        for (int i = 0; i < NCH; i++) wr(i, 0, 2 * i + 3);
        lat(63);
        measure();
        check_all("R10 independent widths");
        chk(frame_gap, PCLK, "R1 period length");

        // R5: clamp sweep on channel 0
        wr(0, 1, 3);
        wr(0, 2, 15);
        for (int v = 0; v <= 20; v++) begin
            wr(0, 0, v);
            lat(1);
            measure();
            chk(meas[0], DIV * clampm(v, 3, 15), "R5 clamp sweep");
            for (int i = 1; i < NCH; i++) chk(meas[i], exp_hi(i), "R10 others unchanged");
        end
        // R5: lower above upper, lower wins
        wr(0, 1, 12);
        wr(0, 2, 8);
        wr(0, 0, 3);
        lat(1);
        measure();
        chk(meas[0], DIV * 12, "R5 lower wins");

        // R6: limit caps
        wr(1, 2, 25);
        wr(1, 0, 25);
        lat(2);
        measure();
        chk(meas[1], DIV * CAPV, "R6 upper capped");
        wr(2, 1, 30);
        wr(2, 0, 0);
        lat(4);
        measure();
        chk(meas[2], DIV * CAPV, "R6 lower capped");

        // R2: compare zero gives a silent period
        wr(2, 1, 0);
        wr(2, 0, 0);
        lat(4);
        measure();
        chk(meas[2], 0, "R2 zero width");
        chk(meas[1], DIV * CAPV, "R2 full cap width");

        // R3: shadow write alone has no effect
        wr(3, 0, 4);
        measure();
        chk(meas[3], DIV * 9, "R3 shadow not yet committed");
        lat(8);
        measure();
        chk(meas[3], DIV * 4, "R3 committed after latch");

        // R4: latch bit self-clears
        wr(3, 0, 11);
        measure();
        chk(meas[3], DIV * 4, "R4 no commit without new latch");
        measure();
        chk(meas[3], DIV * 4, "R4 still no commit");
        check_all("R4 all channels");

        // R7: disable and re-enable
        wr(4, 3, 0);
        measure();
        chk(meas[4], 0, "R7 disabled low");
        wr(4, 3, 1);
        measure();
        chk(meas[4], DIV * 11, "R7 re-enabled");

        // R5: limit change after write does not re-clamp
        wr(5, 0, 10);
        wr(5, 2, 5);
        lat(32);
        measure();
        chk(meas[5], DIV * 10, "R5 no re-clamp");
        wr(5, 0, 10);
        lat(32);
        measure();
        chk(meas[5], DIV * 5, "R5 new limit applies");

        // R9: out-of-range channel index ignored
        wr(6, 0, 1);
        wr(7, 3, 0);
        wr(6, 2, 2);
        lat(63);
        measure();
        check_all("R9 bad index ignored");
        chk(frame_gap, PCLK, "R1 period length late");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule